// File: doc/BRIEF.md
# Serial-Parallel Signed Multiplier (Baugh-Wooley, LSB-first)

This block multiplies a signed coefficient, held in parallel on its input for the length of a frame, by a signed data word that arrives one bit per clock, least significant bit first. It returns the double-width two's-complement product as a serial stream, least significant bit first, one product bit in each slot of a frame that is twice the operand width long. It is the multiplying cell of a bit-level systolic matrix-vector or matrix-matrix engine. The engine around it supplies the two slot strobes and adds up the bit streams of several cells; this block does neither.

Inside, a gate stage builds one column of partial-product bits per slot. In the slot that carries the data sign bit, this stage inverts the terms that hold sign information. A chain of full adders then sums the column. Each adder keeps its carry in a register and hands its registered sum one stage toward the output. The two constant ones that the Baugh-Wooley identity needs are not stored anywhere. They are injected in fixed slots: one through the delayed sign strobe and one through the upper-correction enable. A rising edge on the upper-correction enable marks slot 0 of a frame and clears what the previous frame left in the adder chain. This lets frames follow one another with no idle cycle.

Top module: `bsm_serial_mul`

## Requirements
- R1: For a W-bit coefficient and a W-bit data word, both two's complement, bit t of the 2W-bit product appears on `prod_o` during slot t of the frame (t = 0..2W-1). It is combinational from the data bit of the same slot, so there is no extra latency.
- R2: The coefficient is held constant for the whole frame. `din_i` carries data bit t in slot t for t < W and 0 in slots W..2W-1. A new coefficient may be applied in slot 0 of the next frame, and it takes effect there.
- R3: `sign_slot_i` is high in exactly one slot per frame, slot W-1, when the data sign bit is present. It inverts the sign-bearing partial products, so the most negative value times itself gives a positive product (for W=4, -8 x -8 = 64 = 0100_0000).
- R4: The correction one of weight 2^W enters the output-end adder in slot W, driven by the sign strobe delayed by one clock.
- R5: `hi_corr_en_i` is high in slots 0..W and low in slots W+1..2W-1. Its gating injects the correction one of weight 2^(2W-1) in slot W and blocks the upper constant term in every later slot.
- R6: A 0-to-1 transition of `hi_corr_en_i` marks slot 0. All carry and sum state left by the previous frame is discarded in that slot, so frames may be sent back to back with no idle cycle and each result is independent of the one before.
- R7: After reset, and until the first frame starts, `prod_o` is 0 while `din_i`, `sign_slot_i` and `hi_corr_en_i` are low.
- R8: The product is exact over the full operand range: all 2^(2W) operand pairs give the signed product in 2W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| coef_i | input | W | Signed coefficient, held for the whole frame |
| din_i | input | 1 | Serial data bit, LSB first, zero in the upper W slots |
| sign_slot_i | input | 1 | High in slot W-1 only; inverts sign-bearing terms |
| hi_corr_en_i | input | 1 | High in slots 0..W; its rising edge starts a frame |
| prod_o | output | 1 | Serial product bit, LSB first, bit t in slot t |

## Verification
The bench goes after operand pairs that stress the sign handling. Minus eight times itself would come out negative or overflow if the sign terms were not inverted in the right slot. Seven times minus eight loses its top bit if the upper correction one is missing or mistimed. Seven times seven goes wrong at bit W if the low correction one is shifted by a slot. A zero product sent immediately after minus eight squared shows whether the residue left in the carry and sum registers is cleared at the frame edge; a design that skipped this would print stray ones in the second frame. A full sweep of all operand pairs, sent back to back, covers every carry pattern.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

   // legal operand widths for the serial multiplier
   localparam int unsigned BSM_MIN_W = 2;
   localparam int unsigned BSM_MAX_W = 16;

   typedef struct packed {
      logic sum;
      logic cry;
   } fa_res_t;

   function automatic fa_res_t fa_eval(input logic x, input logic y, input logic z);
      fa_res_t r;
      r.sum = x ^ y ^ z;
      r.cry = (x & y) | (x & z) | (y & z);
      return r;
   endfunction

endpackage

// File: rtl/bsm_fa.sv
module bsm_fa (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   bsm_pkg::fa_res_t res;

   always_comb res = bsm_pkg::fa_eval(a_i, b_i, c_i);

   assign s_o = res.sum;
   assign c_o = res.cry;
endmodule

// File: rtl/bsm_slot_ctl.sv
module bsm_slot_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sign_slot_i,
   input  logic hi_corr_en_i,
   output logic sign_dly_o,
   output logic frame_start_o
);
   logic sign_q;
   logic hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q <= 1'b0;
         hi_q   <= 1'b0;
      end else begin
         sign_q <= sign_slot_i;
         hi_q   <= hi_corr_en_i;
      end
   end

   // slot W carries the low correction one; slot 0 is the enable's rise
   assign sign_dly_o    = sign_q;
   assign frame_start_o = hi_corr_en_i & ~hi_q;
endmodule

// File: rtl/bsm_pp_gen.sv
module bsm_pp_gen #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] coef_i,
   input  logic         din_i,
   input  logic         sign_slot_i,
   input  logic         sign_dly_i,
   input  logic         hi_corr_en_i,
   output logic [W-1:0] pp_o
);
   logic [W-1:0] raw;
   logic [W-1:0] flip;

   for (genvar i = 0; i < W; i++) begin : g_col
      if (i == W - 1) begin : g_top
         // sign coefficient bit: complemented term, gated by the upper enable
         assign raw[i]  = ~(din_i & coef_i[i]);
         assign flip[i] = raw[i] ^ sign_slot_i;
         assign pp_o[i] = flip[i] & hi_corr_en_i;
      end else if (i == 0) begin : g_low
         // output-end column also takes the weight-2^W correction
         assign raw[i]  = din_i & coef_i[i];
         assign flip[i] = raw[i] ^ sign_slot_i;
         assign pp_o[i] = flip[i] | sign_dly_i;
      end else begin : g_mid
         assign raw[i]  = din_i & coef_i[i];
         assign flip[i] = raw[i] ^ sign_slot_i;
         assign pp_o[i] = flip[i];
      end
   end
endmodule

// File: rtl/bsm_csa_chain.sv
module bsm_csa_chain #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] pp_i,
   output logic         bit_o
);
   localparam int unsigned NFA = W - 1;

   // link_q[k] feeds adder k-1; link_q[W-1] holds the top column
   logic [W-1:1]   link_q;
   logic [W-1:1]   link_m;
   logic [NFA-1:0] cry_q;
   logic [NFA-1:0] cry_m;
   logic [NFA-1:0] fa_s;
   logic [NFA-1:0] fa_c;

   assign link_m = clr_i ? '0 : link_q;
   assign cry_m  = clr_i ? '0 : cry_q;

   for (genvar k = 0; k < NFA; k++) begin : g_stage
      bsm_fa u_fa (
         .a_i (pp_i[k]),
         .b_i (link_m[k+1]),
         .c_i (cry_m[k]),
         .s_o (fa_s[k]),
         .c_o (fa_c[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= '0;
         cry_q  <= '0;
      end else begin
         link_q[W-1] <= pp_i[W-1];
         for (int k = 1; k < NFA; k++) begin
            link_q[k] <= fa_s[k];
         end
         cry_q <= fa_c;
      end
   end

   assign bit_o = fa_s[0];
endmodule

// File: rtl/bsm_serial_mul.sv
module bsm_serial_mul #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] coef_i,
   input  logic         din_i,
   input  logic         sign_slot_i,
   input  logic         hi_corr_en_i,
   output logic         prod_o
);
   if (W < bsm_pkg::BSM_MIN_W || W > bsm_pkg::BSM_MAX_W) begin : g_bad_width
      $error("bsm_serial_mul: operand width out of range");
   end

   logic         sign_dly;
   logic         frame_start;
   logic [W-1:0] pp;

   bsm_slot_ctl u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .sign_slot_i   (sign_slot_i),
      .hi_corr_en_i  (hi_corr_en_i),
      .sign_dly_o    (sign_dly),
      .frame_start_o (frame_start)
   );

   bsm_pp_gen #(.W(W)) u_pp (
      .coef_i       (coef_i),
      .din_i        (din_i),
      .sign_slot_i  (sign_slot_i),
      .sign_dly_i   (sign_dly),
      .hi_corr_en_i (hi_corr_en_i),
      .pp_o         (pp)
   );

   bsm_csa_chain #(.W(W)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (frame_start),
      .pp_i  (pp),
      .bit_o (prod_o)
   );
endmodule

// File: rtl/bsm_serial_mul_chk.sv
module bsm_serial_mul_chk #(
   parameter int unsigned W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] coef_i,
   input logic         din_i,
   input logic         sign_slot_i,
   input logic         hi_corr_en_i,
   input logic         prod_o
);
   localparam int unsigned FRAME = 2 * W;
   localparam int unsigned SW    = $clog2(FRAME);

   logic          hi_prev_q;
   logic          in_frame_q;
   logic          seen_q;
   logic [SW-1:0] slot_q;
   logic [W-1:0]  bacc_q;

   logic          start;
   logic          active;
   logic [SW-1:0] cur_slot;
   logic [W-1:0]  bits_now;
   logic signed [FRAME-1:0] ea, eb, prodv;
   logic          exp_bit;

   assign start    = hi_corr_en_i & ~hi_prev_q;
   assign cur_slot = start ? '0 : slot_q + SW'(1);
   assign active   = start | (in_frame_q & (slot_q < SW'(FRAME - 1)));

   // independent reference: signed product of the bits seen so far
   always_comb begin
      bits_now = start ? '0 : bacc_q;
      for (int i = 0; i < W; i++) begin
         if (SW'(i) == cur_slot) bits_now[i] = bits_now[i] | din_i;
      end
      ea      = {{W{coef_i[W-1]}}, coef_i};
      eb      = {{W{bits_now[W-1]}}, bits_now};
      prodv   = ea * eb;
      exp_bit = prodv[cur_slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_prev_q  <= 1'b0;
         in_frame_q <= 1'b0;
         seen_q     <= 1'b0;
         slot_q     <= '0;
         bacc_q     <= '0;
      end else begin
         hi_prev_q  <= hi_corr_en_i;
         in_frame_q <= active;
         if (start) seen_q <= 1'b1;
         if (active) begin
            slot_q <= cur_slot;
            bacc_q <= bits_now;
         end
      end
   end

   p_serial_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (prod_o == exp_bit));

   p_coef_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start) |-> $stable(coef_i));

   p_data_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cur_slot >= SW'(W)) |-> !din_i);

   p_sign_slot_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sign_slot_i |-> (active && cur_slot == SW'(W - 1)));

   p_sign_slot_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sign_slot_i |=> !sign_slot_i);

   p_hi_window_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cur_slot > SW'(W)) |-> !hi_corr_en_i);

   p_hi_window_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cur_slot <= SW'(W)) |-> hi_corr_en_i);

   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && !hi_corr_en_i && !din_i && !sign_slot_i) |-> !prod_o);
endmodule

bind bsm_serial_mul bsm_serial_mul_chk #(.W(W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .coef_i       (coef_i),
   .din_i        (din_i),
   .sign_slot_i  (sign_slot_i),
   .hi_corr_en_i (hi_corr_en_i),
   .prod_o       (prod_o)
);

// File: tb/bsm_serial_mul_tb.sv
module bsm_serial_mul_tb;
   localparam int  W          = 4;
   localparam int  FRAME      = 2 * W;
   localparam time CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] coef = '0;
   logic         din = 1'b0;
   logic         sign_slot = 1'b0;
   logic         hi_en = 1'b0;
   logic         prod;

   int checks = 0;
   int fails  = 0;

   logic [FRAME-1:0] exp_q[$];
   logic [W-1:0]     a_q[$];
   logic [W-1:0]     b_q[$];
   string            tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   bsm_serial_mul #(.W(W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .coef_i       (coef),
      .din_i        (din),
      .sign_slot_i  (sign_slot),
      .hi_corr_en_i (hi_en),
      .prod_o       (prod)
   );

   function automatic logic [FRAME-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
      int sa;
      int sb;
      sa = int'($signed(a));
      sb = int'($signed(b));
      return FRAME'(sa * sb);
   endfunction

   // driver: queue the expected product, then play one frame slot by slot
   task automatic send_frame(input logic [W-1:0] a, input logic [W-1:0] b,
                             input string tag, input int idle);
      exp_q.push_back(ref_prod(a, b));
      a_q.push_back(a);
      b_q.push_back(b);
      tag_q.push_back(tag);
      for (int t = 0; t < FRAME; t++) begin
         @(negedge clk);
         if (t == 0) coef = a;
         din       = (t < W) ? b[t] : 1'b0;
         sign_slot = (t == W - 1);
         hi_en     = (t <= W);
      end
      for (int i = 0; i < idle; i++) begin
         @(negedge clk);
         din       = 1'b0;
         sign_slot = 1'b0;
         hi_en     = 1'b0;
      end
   endtask

   // monitor: gather one product per frame and compare with the queue head
   initial begin
      logic             prev_hi;
      logic             active;
      int               cnt;
      logic [FRAME-1:0] got;
      logic [FRAME-1:0] exp_v;
      logic [W-1:0]     av;
      logic [W-1:0]     bv;
      string            tg;
      prev_hi = 1'b0;
      active  = 1'b0;
      cnt     = 0;
      got     = '0;
      forever begin
         @(negedge clk);
         #(CLK_PERIOD / 4);
         if (!rst_n) begin
            prev_hi = 1'b0;
            active  = 1'b0;
            continue;
         end
         if (hi_en && !prev_hi) begin
            active = 1'b1;
            cnt    = 0;
            got    = '0;
         end
         prev_hi = hi_en;
         if (active) begin
            got[cnt] = prod;
            cnt++;
            if (cnt == FRAME) begin
               active = 1'b0;
               checks++;
               if (exp_q.size() == 0) begin
                  fails++;
                  $display("FAIL R1: product frame with nothing queued, actual=%b expected=none", got);
               end else begin
                  exp_v = exp_q.pop_front();
                  av    = a_q.pop_front();
                  bv    = b_q.pop_front();
                  tg    = tag_q.pop_front();
                  if (got !== exp_v) begin
                     fails++;
                     $display("FAIL %s: coef=%0d data=%0d actual=%b expected=%b",
                              tg, $signed(av), $signed(bv), got, exp_v);
                  end
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R7: output low in reset and in the idle cycles after it
      repeat (3) @(negedge clk);
      #(CLK_PERIOD / 4);
      checks++;
      if (prod !== 1'b0) begin
         fails++;
         $display("FAIL R7: output during reset actual=%b expected=0", prod);
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         #(CLK_PERIOD / 4);
         checks++;
         if (prod !== 1'b0) begin
            fails++;
            $display("FAIL R7: idle output after reset actual=%b expected=0", prod);
         end
      end

      // R1: basic signs, with an idle gap
      send_frame(4'd2, 4'd3, "R1 2x3", 2);
      send_frame(4'hF, 4'd6, "R1 -1x6", 0);
      // R3: sign inversion, most negative squared
      send_frame(4'h8, 4'h8, "R3 -8x-8", 0);
      // R5: upper correction one
      send_frame(4'd7, 4'h8, "R5 7x-8", 0);
      send_frame(4'h8, 4'd7, "R5 -8x7", 0);
      // R4: low correction one at bit W
      send_frame(4'd7, 4'd7, "R4 7x7", 0);
      // R2: coefficient changes at the frame edge, same data
      send_frame(4'd5, 4'hD, "R2 5x-3", 0);
      send_frame(4'hB, 4'hD, "R2 -5x-3", 0);
      // R6: heavy residue followed by a zero product, back to back
      send_frame(4'h8, 4'h8, "R6 -8x-8 lead", 0);
      send_frame(4'd0, 4'd0, "R6 0x0 after residue", 0);
      send_frame(4'd1, 4'd1, "R6 1x1 after zero", 1);
      // R8: every operand pair, no idle cycle between frames
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            send_frame(W'(a), W'(b), "R8 sweep", 0);
         end
      end

      repeat (4) @(negedge clk);
      #(CLK_PERIOD / 4);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1: products still pending actual=%0d expected=0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule